// File: doc/BRIEF.md
# Power-Down Entry and Wake Controller

This block decides whether a power-down request from the core takes effect, and which events bring the device back out of power-down. A single configuration bit chooses between two wake schemes. In scheme 0, the NMI pin level gates entry, and only an external reset can end the power-down state. In scheme 1, entry is allowed only while every enabled fast interrupt pin is idle, and any enabled pin that turns active wakes the device. An external reset also wakes the device in scheme 1.

The `pd_o` output gates the core clocks further down the chip. The wake-cause outputs record why the last power-down ended. Each interrupt pin has its own enable bit and its own active-level bit. Pin inputs are assumed to be synchronized already.

Top module: `pd_ctrl`

## Requirements
- R1: After `rst_ni` the outputs read as follows: `pd_o` = 0, `wake_valid_o` = 0, `wake_src_o` = 0 (none), `wake_pin_o` = 0 and `wake_cfg_o` = 0.
- R2: In scheme 0, a strobe on `pd_req_i` with `nmi_i` low sets `pd_o` on the next cycle. The same strobe with `nmi_i` high leaves `pd_o` at 0.
- R3: In scheme 0, interrupt pins never clear `pd_o`. Only `ext_rst_i` ends power-down in this scheme.
- R4: In scheme 1, a strobe sets `pd_o` only if no enabled pin is active in the strobe cycle. Pin i is active when `exi_i[i]` equals `exi_pol_i[i]`, so a polarity bit of 1 means active-high. A pin that turns active in the strobe cycle blocks entry.
- R5: In scheme 1, pins whose `exi_en_i` bit is 0 are ignored. They neither block entry nor wake the device.
- R6: In scheme 1 during power-down, an enabled active pin clears `pd_o` on the next cycle. In that same cycle, `wake_valid_o` pulses for one cycle, `wake_src_o` reads 2 (pin) and `wake_pin_o` holds the lowest active enabled index.
- R7: `ext_rst_i` clears `pd_o` and returns the scheme to 0 on the next cycle. It sets `wake_src_o` to 1 (reset) and `wake_pin_o` to 0. It pulses `wake_valid_o` only if `pd_o` was high. It takes priority over pin wakes.
- R8: Entry is evaluated only in a cycle where `pd_req_i` is high. Pin or NMI changes without a strobe never set `pd_o`.
- R9: A write through `cfg_we_i` and `cfg_d_i` updates `wake_cfg_o` on the next cycle, but only while `pd_o` is low. A strobe in the same cycle as the write is judged under the old scheme. Writes are ignored while `pd_o` is high.
- R10: A successful entry sets `wake_src_o` and `wake_pin_o` to 0. A strobe while `pd_o` is already high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pd_req_i | input | 1 | One-cycle power-down instruction strobe |
| cfg_we_i | input | 1 | Wake-scheme write enable |
| cfg_d_i | input | 1 | Wake-scheme write data |
| nmi_i | input | 1 | NMI pin level |
| exi_i | input | N_PINS | Fast interrupt pin levels |
| exi_en_i | input | N_PINS | Per-pin enable |
| exi_pol_i | input | N_PINS | Per-pin active level (1 = active high) |
| ext_rst_i | input | 1 | External reset event |
| pd_o | output | 1 | Power-down state, gates core clocks |
| wake_valid_o | output | 1 | One-cycle pulse when power-down ends |
| wake_src_o | output | 2 | Last wake cause: 0 none, 1 reset, 2 pin |
| wake_pin_o | output | PIN_W | Index of the waking pin |
| wake_cfg_o | output | 1 | Current wake scheme |

## Verification
The bench targets the following corner cases and the failure each one would expose:
- A pin that turns active in the very cycle of the strobe. A design that registered the guard late would enter and then wake straight away.
- Disabled pins that are active, both at entry and during power-down. A design that skipped the enable mask would refuse entry or wake spuriously.
- Several pins turning active at once. A wrong priority encoder would report a higher index than the lowest active pin.
- A scheme write during power-down, and a reset that arrives together with a pin wake. A design that let the write through would wake on pins in scheme 0. A design with the wrong priority would report the pin as the wake cause instead of the reset.

// File: rtl/pd_pkg.sv
package pd_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_RST  = 2'd1,
    SRC_PIN  = 2'd2
  } wake_src_e;
endpackage

// File: rtl/pd_pin_eval.sv
module pd_pin_eval #(
  parameter int N_PINS = 4,
  localparam int PIN_W = (N_PINS > 1) ? $clog2(N_PINS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] exi_i,
  input  logic [N_PINS-1:0] exi_en_i,
  input  logic [N_PINS-1:0] exi_pol_i,
  output logic              any_act_o,
  output logic [PIN_W-1:0]  first_idx_o
);
  logic [N_PINS-1:0] act;

  for (genvar g = 0; g < N_PINS; g++) begin : g_pin
    assign act[g] = exi_en_i[g] & ~(exi_i[g] ^ exi_pol_i[g]);
  end

  assign any_act_o = |act;

  // lowest index wins: scan downward, last hit overrides
  always_comb begin
    first_idx_o = '0;
    for (int i = N_PINS - 1; i >= 0; i--) begin
      if (act[i]) first_idx_o = PIN_W'(i);
    end
  end

  a_r6_idx_is_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_act_o |-> (exi_en_i[first_idx_o] && (exi_i[first_idx_o] == exi_pol_i[first_idx_o])));
endmodule

// File: rtl/pd_entry_guard.sv
module pd_entry_guard (
  input  logic cfg_i,
  input  logic nmi_i,
  input  logic any_act_i,
  output logic guard_o
);
  // scheme 0: NMI must be low; scheme 1: every enabled pin idle
  always_comb begin
    if (cfg_i) guard_o = ~any_act_i;
    else       guard_o = ~nmi_i;
  end
endmodule

// File: rtl/pd_fsm.sv
module pd_fsm
  import pd_pkg::*;
#(
  parameter int PIN_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pd_req_i,
  input  logic             cfg_we_i,
  input  logic             cfg_d_i,
  input  logic             ext_rst_i,
  input  logic             guard_i,
  input  logic             any_act_i,
  input  logic [PIN_W-1:0] first_idx_i,
  output logic             cfg_o,
  output logic             pd_o,
  output logic             wake_valid_o,
  output wake_src_e        wake_src_o,
  output logic [PIN_W-1:0] wake_pin_o
);
  logic             pd_q, cfg_q, wv_q;
  wake_src_e        src_q;
  logic [PIN_W-1:0] pin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pd_q  <= 1'b0;
      cfg_q <= 1'b0;
      wv_q  <= 1'b0;
      src_q <= SRC_NONE;
      pin_q <= '0;
    end else begin
      wv_q <= 1'b0;
      if (ext_rst_i) begin
        pd_q  <= 1'b0;
        cfg_q <= 1'b0;
        src_q <= SRC_RST;
        pin_q <= '0;
        wv_q  <= pd_q;
      end else if (pd_q) begin
        if (cfg_q && any_act_i) begin
          pd_q  <= 1'b0;
          src_q <= SRC_PIN;
          pin_q <= first_idx_i;
          wv_q  <= 1'b1;
        end
      end else begin
        if (cfg_we_i) cfg_q <= cfg_d_i;
        if (pd_req_i && guard_i) begin
          pd_q  <= 1'b1;
          src_q <= SRC_NONE;
          pin_q <= '0;
        end
      end
    end
  end

  assign pd_o         = pd_q;
  assign cfg_o        = cfg_q;
  assign wake_valid_o = wv_q;
  assign wake_src_o   = src_q;
  assign wake_pin_o   = pin_q;

  a_r3_cfg0_reset_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd_q && !cfg_q && !ext_rst_i) |=> pd_q);
  a_r7_ext_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_rst_i |=> (!pd_q && !cfg_q && src_q == SRC_RST));
  a_r8_entry_needs_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pd_q && !pd_req_i) |=> !pd_q);
  a_r9_cfg_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd_q && !ext_rst_i) |=> $stable(cfg_q));
  a_r6_pin_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd_q && !ext_rst_i && cfg_q && any_act_i) |=> (wv_q && src_q == SRC_PIN));
endmodule

// File: rtl/pd_ctrl.sv
module pd_ctrl
  import pd_pkg::*;
#(
  parameter int N_PINS = 4,
  localparam int PIN_W = (N_PINS > 1) ? $clog2(N_PINS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pd_req_i,
  input  logic              cfg_we_i,
  input  logic              cfg_d_i,
  input  logic              nmi_i,
  input  logic [N_PINS-1:0] exi_i,
  input  logic [N_PINS-1:0] exi_en_i,
  input  logic [N_PINS-1:0] exi_pol_i,
  input  logic              ext_rst_i,
  output logic              pd_o,
  output logic              wake_valid_o,
  output logic [1:0]        wake_src_o,
  output logic [PIN_W-1:0]  wake_pin_o,
  output logic              wake_cfg_o
);
  logic             any_act, guard;
  logic [PIN_W-1:0] first_idx;
  wake_src_e        src;

  pd_pin_eval #(.N_PINS(N_PINS)) i_pin_eval (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .exi_i       (exi_i),
    .exi_en_i    (exi_en_i),
    .exi_pol_i   (exi_pol_i),
    .any_act_o   (any_act),
    .first_idx_o (first_idx)
  );

  pd_entry_guard i_guard (
    .cfg_i     (wake_cfg_o),
    .nmi_i     (nmi_i),
    .any_act_i (any_act),
    .guard_o   (guard)
  );

  pd_fsm #(.PIN_W(PIN_W)) i_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pd_req_i     (pd_req_i),
    .cfg_we_i     (cfg_we_i),
    .cfg_d_i      (cfg_d_i),
    .ext_rst_i    (ext_rst_i),
    .guard_i      (guard),
    .any_act_i    (any_act),
    .first_idx_i  (first_idx),
    .cfg_o        (wake_cfg_o),
    .pd_o         (pd_o),
    .wake_valid_o (wake_valid_o),
    .wake_src_o   (src),
    .wake_pin_o   (wake_pin_o)
  );

  assign wake_src_o = src;

  a_r2_nmi_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pd_o && !wake_cfg_o && nmi_i && !ext_rst_i) |=> !pd_o);
  a_r4_active_pin_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pd_o && wake_cfg_o && |(exi_en_i & ~(exi_i ^ exi_pol_i))) |=> !pd_o);
endmodule

// File: tb/test_pd_ctrl.sv
module test_pd_ctrl;
  localparam int N = 4;
  localparam int PW = 2;

  logic clk = 0, rst_ni = 0;
  logic pd_req = 0, cfg_we = 0, cfg_d = 0, nmi = 0, ext_rst = 0;
  logic [N-1:0] exi = '0, en = '0, pol = '0;
  logic pd, wv, cfg;
  logic [1:0] src;
  logic [PW-1:0] wpin;

  int n_chk = 0, n_fail = 0;

  // model state
  logic m_pd = 0, m_cfg = 0, m_wv = 0;
  logic [1:0] m_src = 0;
  logic [PW-1:0] m_pin = 0;
  string m_tag = "R1";

  always #4 clk = ~clk;

  pd_ctrl #(.N_PINS(N)) i_pd_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .pd_req_i(pd_req), .cfg_we_i(cfg_we),
    .cfg_d_i(cfg_d), .nmi_i(nmi), .exi_i(exi), .exi_en_i(en),
    .exi_pol_i(pol), .ext_rst_i(ext_rst), .pd_o(pd), .wake_valid_o(wv),
    .wake_src_o(src), .wake_pin_o(wpin), .wake_cfg_o(cfg)
  );

  function automatic logic [N-1:0] act_vec(logic [N-1:0] p, logic [N-1:0] e, logic [N-1:0] l);
    return e & ~(p ^ l);
  endfunction

  function automatic logic [PW-1:0] low_idx(logic [N-1:0] a);
    for (int i = 0; i < N; i++) if (a[i]) return PW'(i);
    return '0;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all();
    chk(m_tag, "pd_o", pd, m_pd);
    chk(m_tag, "wake_valid_o", wv, m_wv);
    chk(m_tag, "wake_src_o", src, m_src);
    chk(m_tag, "wake_pin_o", wpin, m_pin);
    chk(m_tag, "wake_cfg_o", cfg, m_cfg);
  endtask

  // inputs already driven; advance one clock and compare
  task automatic cyc();
    logic [N-1:0] a;
    logic guard;
    a = act_vec(exi, en, pol);
    guard = m_cfg ? (a == '0) : !nmi;
    m_wv = 0;
    if (ext_rst) begin
      m_tag = "R7"; m_wv = m_pd; m_pd = 0; m_cfg = 0; m_src = 1; m_pin = 0;
    end else if (m_pd) begin
      if (m_cfg && a != '0) begin
        m_tag = "R6"; m_pd = 0; m_src = 2; m_pin = low_idx(a); m_wv = 1;
      end else m_tag = m_cfg ? "R5" : "R3";
    end else begin
      m_tag = cfg_we ? "R9" : "R8";
      if (pd_req) begin
        m_tag = m_cfg ? "R4" : "R2";
        if (guard) begin m_pd = 1; m_src = 0; m_pin = 0; end
      end
      if (cfg_we) m_cfg = cfg_d;
    end
    @(posedge clk);
    @(negedge clk);
    check_all();
  endtask

  task automatic idle();
    pd_req = 0; cfg_we = 0; ext_rst = 0;
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    m_tag = "R1";
    check_all();

    // R2: NMI high blocks entry, low allows it
    nmi = 1; pd_req = 1; cyc(); idle();
    nmi = 0; pd_req = 1; cyc(); idle();
    // R3: scheme 0 ignores pins
    en = '1; pol = '1; exi = '1; cyc(); cyc();
    // R10: strobe while in power-down
    pd_req = 1; cyc(); idle();
    // R9: write ignored in power-down
    cfg_we = 1; cfg_d = 1; cyc(); idle();
    // R7: external reset wakes
    ext_rst = 1; cyc(); idle();
    chk("R7", "wake_src reset", src, 1);
    // R9: write scheme 1
    exi = '0; cfg_we = 1; cfg_d = 1; cyc(); idle();
    chk("R9", "cfg written", cfg, 1);
    // R4: pin active in strobe cycle blocks entry
    exi = 4'b0100; pd_req = 1; cyc(); idle();
    chk("R4", "blocked entry", pd, 0);
    // R5: disabled active pin does not block
    en = 4'b1011; pd_req = 1; cyc(); idle();
    chk("R5", "entry with masked pin", pd, 1);
    // R5: disabled pin does not wake
    exi = 4'b0100; cyc();
    // R6: two pins active -> lowest index, active-low pin
    pol = 4'b1101; exi = 4'b1000; cyc();
    chk("R6", "wake pin idx", wpin, 1);
    // R7 priority over pins
    exi = 4'b0000; pol = '1; pd_req = 1; cyc(); idle();
    exi = 4'b0001; ext_rst = 1; cyc(); idle();
    chk("R7", "reset beats pin", src, 1);

    // random phase
    for (int k = 0; k < 4000; k++) begin
      pd_req  = ($urandom % 6) == 0;
      cfg_we  = ($urandom % 12) == 0;
      cfg_d   = ($urandom % 3) != 0;
      ext_rst = ($urandom % 60) == 0;
      nmi     = ($urandom % 3) == 0;
      if (($urandom % 4) == 0) exi = N'($urandom);
      if (($urandom % 16) == 0) en = N'($urandom);
      if (($urandom % 16) == 0) pol = N'($urandom);
      cyc();
    end
    idle();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule